// File: doc/BRIEF.md
# Input-Capture Timer Channel with Selectable Count Source

This block is one channel of a capture timer. It holds an up-counter, 16 bits wide by default, that advances on a count source picked by an 8-bit control register. The source can be the system clock itself, one of four prescaled enables (divide by 2, 4, 8 or 32), a fast on-chip tick supplied as a clock enable, or an external clock pin. The external pin is counted on its rising edges, its falling edges or both. Software loads the control register through a simple write strobe.

The counter can run freely or be cleared by a chosen capture event. The capture registers are outside this block and appear only as four event strobes, A to D. In lockstep mode the channel clears whenever a sibling channel clears. For that purpose the channel drives a clear-request output in the same cycle as its own capture-triggered clear. Reserved control codes stop the counter (source field) or disable clearing (clear field), so an undefined setting never makes the counter run.

Top module: `capture_timer_ch`

## Requirements
- R1: After reset the count is 0 and the control register is 00h. With that value the counter advances by one on every clock, with no clear.
- R2: Source codes (control bits [2:0]) 001, 010, 011 and 100 advance the counter exactly once per 2, 4, 8 and 32 clocks. The enables come from a free-running 5-bit divider.
- R3: Source code 110 advances the counter in exactly those cycles in which the fast-tick input is high.
- R4: Source code 111 is reserved. The counter holds its value.
- R5: Source code 101 counts the external pin after a two-flop synchronizer, with one count per detected edge. Edge code (control bits [4:3]) 00 counts rising edges, 01 counts falling edges and 10 counts both. 11 counts nothing.
- R6: With source code 101 and the external-clock-enable input low, the counter holds.
- R7: Clear code (control bits [7:5]) 001 clears on strobe A (cap_evt[0]), 010 on B (cap_evt[1]), 101 on C (cap_evt[2]) and 110 on D (cap_evt[3]). The other strobes have no effect.
- R8: A clear and a count enable in the same cycle give a count of 0 after that edge.
- R9: Clear code 011 clears the counter when the sibling clear input is high and the sync-mode input is 1. With sync-mode 0 the sibling input has no effect.
- R10: Clear codes 000, 100 and 111 ignore every strobe and the sibling input.
- R11: clr_req_out is high, combinationally, in exactly the cycles in which a capture strobe clears the counter. It stays low for sibling-driven clears.
- R12: The counter wraps from its all-ones value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ext_clk_pin | input | 1 | External clock pin (asynchronous) |
| ext_clk_en | input | 1 | External clock input enable |
| fast_tick | input | 1 | Fast on-chip clock enable |
| cap_evt | input | 4 | Capture event strobes A (bit 0) to D (bit 3) |
| sib_clr_in | input | 1 | Clear request from the sibling channel |
| sync_mode | input | 1 | Synchronous-operation mode enable |
| count | output | CNT_W | Counter value |
| clr_req_out | output | 1 | Capture-clear request to the sibling channel |

## Verification
The bench builds the channel with CNT_W = 10 and keeps the 5-bit prescaler. The wrap from all ones to zero then takes 1024 clocks rather than 65536, so the wrap check fits inside a short directed run. The prescaled sources are measured over 64-clock windows. Because 64 is a multiple of every divide ratio, the expected counts are exact whatever the divider phase. The external-pin cases hold each level for six clocks, which exceeds the three-clock synchronizer and edge latency, so every edge is counted before the window closes.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    typedef enum logic [2:0] {
        SRC_DIV1  = 3'b000,
        SRC_DIV2  = 3'b001,
        SRC_DIV4  = 3'b010,
        SRC_DIV8  = 3'b011,
        SRC_DIV32 = 3'b100,
        SRC_EXT   = 3'b101,
        SRC_FAST  = 3'b110,
        SRC_STOP  = 3'b111
    } src_sel_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_sel_e;

    typedef enum logic [2:0] {
        CLR_OFF  = 3'b000,
        CLR_CAPA = 3'b001,
        CLR_CAPB = 3'b010,
        CLR_SIB  = 3'b011,
        CLR_RSV4 = 3'b100,
        CLR_CAPC = 3'b101,
        CLR_CAPD = 3'b110,
        CLR_RSV7 = 3'b111
    } clr_sel_e;

    // Packed MSB first: clear [7:5], edge [4:3], source [2:0]
    typedef struct packed {
        clr_sel_e  clr;
        edge_sel_e edge_m;
        src_sel_e  src;
    } ctl_t;

    localparam int NUM_CAP = 4;

endpackage

// File: rtl/cap_presc.sv
module cap_presc #(
    parameter int PRESC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PRESC_W-1:0] tick
);
    typedef struct packed {
        logic [PRESC_W-1:0] div;
    } presc_st_t;

    presc_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.div = cur_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // tick[g] fires once every 2^(g+1) clocks
    for (genvar g = 0; g < PRESC_W; g++) begin : g_tap
        assign tick[g] = &cur_q.div[g:0];
    end
endmodule

// File: rtl/cap_ext_edge.sv
module cap_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } edge_st_t;

    edge_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.s1   = pin;
        nxt_d.s2   = cur_q.s1;
        nxt_d.prev = cur_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rise = cur_q.s2 & ~cur_q.prev;
    assign fall = ~cur_q.s2 & cur_q.prev;
endmodule

// File: rtl/cap_clr_sel.sv
module cap_clr_sel
    import cap_timer_pkg::*;
(
    input  clr_sel_e           code,
    input  logic [NUM_CAP-1:0] cap_evt,
    input  logic               sib_clr_in,
    input  logic               sync_mode,
    output logic               cap_clr,
    output logic               sib_clr
);
    always_comb begin
        cap_clr = 1'b0;
        sib_clr = 1'b0;
        unique case (code)
            CLR_CAPA: cap_clr = cap_evt[0];
            CLR_CAPB: cap_clr = cap_evt[1];
            CLR_CAPC: cap_clr = cap_evt[2];
            CLR_CAPD: cap_clr = cap_evt[3];
            CLR_SIB:  sib_clr = sib_clr_in & sync_mode;
            default:  begin
                cap_clr = 1'b0;
                sib_clr = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/capture_timer_ch.sv
module capture_timer_ch
    import cap_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRESC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic [7:0]         ctl_wdata,
    input  logic               ext_clk_pin,
    input  logic               ext_clk_en,
    input  logic               fast_tick,
    input  logic [NUM_CAP-1:0] cap_evt,
    input  logic               sib_clr_in,
    input  logic               sync_mode,
    output logic [CNT_W-1:0]   count,
    output logic               clr_req_out
);
    localparam int TAP2  = 0;
    localparam int TAP4  = 1;
    localparam int TAP8  = 2;
    localparam int TAP32 = 4;

    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] cnt;
    } ch_st_t;

    ch_st_t cur_q, nxt_d;

    logic [PRESC_W-1:0] tick;
    logic               ext_rise, ext_fall;
    logic               cap_clr, sib_clr;
    logic               cnt_en;
    logic               ext_hit;
    logic [7:0]         ctl_bits;

    cap_presc #(.PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    cap_ext_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk_pin),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    cap_clr_sel u_clr (
        .code       (cur_q.ctl.clr),
        .cap_evt    (cap_evt),
        .sib_clr_in (sib_clr_in),
        .sync_mode  (sync_mode),
        .cap_clr    (cap_clr),
        .sib_clr    (sib_clr)
    );

    always_comb begin
        ext_hit = 1'b0;
        unique case (cur_q.ctl.edge_m)
            EDGE_RISE: ext_hit = ext_rise;
            EDGE_FALL: ext_hit = ext_fall;
            EDGE_BOTH: ext_hit = ext_rise | ext_fall;
            default:   ext_hit = 1'b0;
        endcase
    end

    always_comb begin
        cnt_en = 1'b0;
        unique case (cur_q.ctl.src)
            SRC_DIV1:  cnt_en = 1'b1;
            SRC_DIV2:  cnt_en = tick[TAP2];
            SRC_DIV4:  cnt_en = tick[TAP4];
            SRC_DIV8:  cnt_en = tick[TAP8];
            SRC_DIV32: cnt_en = tick[TAP32];
            SRC_EXT:   cnt_en = ext_clk_en & ext_hit;
            SRC_FAST:  cnt_en = fast_tick;
            default:   cnt_en = 1'b0;
        endcase
    end

    always_comb begin
        nxt_d = cur_q;
        if (ctl_we) nxt_d.ctl = ctl_t'(ctl_wdata);
        if (cap_clr || sib_clr) nxt_d.cnt = '0;
        else if (cnt_en)        nxt_d.cnt = cur_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign count       = cur_q.cnt;
    assign clr_req_out = cap_clr;
    assign ctl_bits    = cur_q.ctl;
endmodule

// File: rtl/capture_timer_ch_chk.sv
module capture_timer_ch_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctl,
    input logic [CNT_W-1:0] count,
    input logic             clr_req_out,
    input logic             sib_clr_in,
    input logic             sync_mode
);
    // R1, R12: the count only holds, steps by one (wrapping) or drops to 0
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1) || count == '0));

    // R8: a capture clear request is followed by a zero count
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_out |=> count == '0);

    // R4: reserved source with clearing off keeps the count
    a_r4_reserved_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[2:0] == 3'b111 && ctl[7:5] == 3'b000) |=> $stable(count));

    // R9: lockstep clear follows the sibling
    a_r9_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[7:5] == 3'b011 && sync_mode && sib_clr_in) |=> count == '0);

    // R10, R11: the request only appears under the four capture clear codes
    a_r11_req_codes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_out |-> (ctl[7:5] == 3'b001 || ctl[7:5] == 3'b010 ||
                         ctl[7:5] == 3'b101 || ctl[7:5] == 3'b110));
endmodule

bind capture_timer_ch capture_timer_ch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl_bits),
    .count       (count),
    .clr_req_out (clr_req_out),
    .sib_clr_in  (sib_clr_in),
    .sync_mode   (sync_mode)
);

// File: tb/tb_capture_timer_ch.sv
module tb_capture_timer_ch;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int MODV       = 1 << CNT_W;
    localparam int WDOG       = 200000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_we = 1'b0;
    logic [7:0]       ctl_wdata = '0;
    logic             ext_clk_pin = 1'b0;
    logic             ext_clk_en = 1'b0;
    logic             fast_tick = 1'b0;
    logic [3:0]       cap_evt = '0;
    logic             sib_clr_in = 1'b0;
    logic             sync_mode = 1'b0;
    logic [CNT_W-1:0] count;
    logic             clr_req_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    capture_timer_ch #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ext_clk_pin(ext_clk_pin), .ext_clk_en(ext_clk_en), .fast_tick(fast_tick),
        .cap_evt(cap_evt), .sib_clr_in(sib_clr_in), .sync_mode(sync_mode),
        .count(count), .clr_req_out(clr_req_out)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    function automatic int delta(input int a, input int b);
        return (b - a + MODV) % MODV;
    endfunction

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check_eq("R1 count in reset", int'(count), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check_eq("R1 undivided after reset", int'(count), 20);
    endtask

    task automatic t_wrap;
        int c;
        c = int'(count);
        repeat (MODV - c) @(negedge clk);
        check_eq("R12 wrap to zero", int'(count), 0);
        @(negedge clk);
        check_eq("R12 count after wrap", int'(count), 1);
    endtask

    task automatic t_presc;
        int c;
        for (int k = 1; k <= 4; k++) begin
            write_ctl(8'(k));
            c = int'(count);
            repeat (64) @(negedge clk);
            check_eq($sformatf("R2 source %0d over 64 clocks", k),
                     delta(c, int'(count)), (k == 4) ? 2 : (64 >> k));
        end
    endtask

    task automatic t_fast;
        int c;
        write_ctl(8'h06);
        c = int'(count);
        for (int i = 0; i < 40; i++) begin
            fast_tick = (i % 3 == 0);
            @(negedge clk);
        end
        fast_tick = 1'b0;
        check_eq("R3 fast tick count", delta(c, int'(count)), 14);
    endtask

    task automatic t_stop;
        int c;
        write_ctl(8'h07);
        c = int'(count);
        repeat (30) @(negedge clk);
        check_eq("R4 reserved source holds", delta(c, int'(count)), 0);
    endtask

    task automatic ext_run(input logic [1:0] em, input logic en, input int exp, input string tag);
        int c;
        ext_clk_en = en;
        write_ctl({3'b000, em, 3'b101});
        repeat (4) @(negedge clk);
        c = int'(count);
        for (int i = 0; i < 4; i++) begin
            ext_clk_pin = 1'b1;
            repeat (6) @(negedge clk);
            ext_clk_pin = 1'b0;
            repeat (6) @(negedge clk);
        end
        check_eq(tag, delta(c, int'(count)), exp);
    endtask

    task automatic t_ext;
        ext_run(2'b00, 1'b1, 4, "R5 rising edges");
        ext_run(2'b01, 1'b1, 4, "R5 falling edges");
        ext_run(2'b10, 1'b1, 8, "R5 both edges");
        ext_run(2'b11, 1'b1, 0, "R5 reserved edge code");
        ext_run(2'b10, 1'b0, 0, "R6 external disabled");
        ext_clk_en = 1'b0;
    endtask

    task automatic clear_case(input logic [2:0] code, input int bitn, input string tag);
        int c;
        write_ctl({code, 5'b00000});
        repeat (3) @(negedge clk);
        c = int'(count);
        cap_evt = ~(4'b1 << bitn);
        #1;
        check_eq({tag, " R7 other strobes no request"}, int'(clr_req_out), 0);
        @(negedge clk);
        cap_evt = '0;
        check_eq({tag, " R7 other strobes ignored"}, int'(count), (c + 1) % MODV);
        cap_evt = 4'b1 << bitn;
        #1;
        check_eq({tag, " R11 request raised"}, int'(clr_req_out), 1);
        @(negedge clk);
        cap_evt = '0;
        check_eq({tag, " R8 clear beats count"}, int'(count), 0);
    endtask

    task automatic t_cap_clear;
        clear_case(3'b001, 0, "strobe A");
        clear_case(3'b010, 1, "strobe B");
        clear_case(3'b101, 2, "strobe C");
        clear_case(3'b110, 3, "strobe D");
    endtask

    task automatic t_sync;
        int c;
        write_ctl(8'h60);
        repeat (3) @(negedge clk);
        sync_mode = 1'b0;
        c = int'(count);
        sib_clr_in = 1'b1;
        @(negedge clk);
        sib_clr_in = 1'b0;
        check_eq("R9 sibling ignored without sync mode", int'(count), (c + 1) % MODV);
        sync_mode = 1'b1;
        repeat (2) @(negedge clk);
        sib_clr_in = 1'b1;
        #1;
        check_eq("R11 no request on sibling clear", int'(clr_req_out), 0);
        @(negedge clk);
        sib_clr_in = 1'b0;
        check_eq("R9 sibling clear", int'(count), 0);
    endtask

    task automatic t_no_clear;
        int c;
        logic [2:0] codes [3] = '{3'b000, 3'b100, 3'b111};
        sync_mode = 1'b1;
        for (int i = 0; i < 3; i++) begin
            write_ctl({codes[i], 5'b00000});
            repeat (2) @(negedge clk);
            c = int'(count);
            cap_evt = 4'hF;
            sib_clr_in = 1'b1;
            #1;
            check_eq($sformatf("R10 code %0d no request", codes[i]), int'(clr_req_out), 0);
            @(negedge clk);
            cap_evt = '0;
            sib_clr_in = 1'b0;
            check_eq($sformatf("R10 code %0d no clear", codes[i]), int'(count), (c + 1) % MODV);
        end
        sync_mode = 1'b0;
    endtask

    initial begin
        t_reset();
        t_wrap();
        t_presc();
        t_fast();
        t_stop();
        t_ext();
        t_cap_clear();
        t_sync();
        t_no_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule